// File: doc/BRIEF.md
# AES-256 Round-Key Expansion Unit

This unit turns a 256-bit cipher key into the fifteen 128-bit round keys of AES-256 and stores them in a 16-entry round-key RAM. The encryption core reads that RAM through its own read port. The key enters as eight 32-bit segments, most significant word first. A separate strobe tells the unit that all eight segments are in place, and the expansion then runs with no further input.

The unit holds the eight most recent expanded words in a sliding window of 32-bit registers. In each cycle it derives one new word from the oldest and the newest word in the window and shifts the window by one place. Whenever the oldest window slot holds a word whose index is a multiple of four, the four oldest slots are written together as one RAM entry. A completion flag rises once the last entry has been written. That flag falls again as soon as a new key segment is loaded or a new expansion is started.

Top module: `aes256_key_sched`

## Requirements
- R1: Each cycle with `keySegValid` high shifts `keySegIn` into the window. The first of eight segments becomes W[0], and RAM entries 0 and 1 equal the loaded key.
- R2: A `keyLoaded` pulse starts the expansion. `keysReady` rises exactly 57 rising clock edges after the edge that samples `keyLoaded`.
- R3: For i from 8 to 59 with i mod 8 not 0 and not 4, W[i] = W[i-8] XOR W[i-1].
- R4: For i mod 8 == 0, W[i] = W[i-8] XOR SubWord(RotWord(W[i-1])) XOR {rc, 24'h0}. RotWord moves bits 31:24 to bits 7:0 and shifts the other bytes up one place. rc is 01, 02, 04, 08, 10, 20, 40 for i/8 = 1 to 7.
- R5: For i mod 8 == 4, W[i] = W[i-8] XOR SubWord(W[i-1]), with no rotation and no round constant.
- R6: RAM entry k (k = 0 to 14) holds W[4k] in bits 127:96, W[4k+1] in bits 95:64, W[4k+2] in bits 63:32 and W[4k+3] in bits 31:0. No entry is written while `keysReady` is high.
- R7: `rdData` presents the entry addressed by `rdAddr` one clock cycle after that address is sampled, for any order of addresses.
- R8: `keysReady` is low after reset. It goes low on the edge after a segment load or a `keyLoaded` pulse, stays low until the expansion completes, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| keySegIn | input | 32 | One 32-bit key segment |
| keySegValid | input | 1 | Shift `keySegIn` into the window this cycle |
| keyLoaded | input | 1 | All eight segments are loaded; start the expansion |
| rdAddr | input | 4 | Round-key RAM read address |
| rdData | output | 128 | Registered read data |
| keysReady | output | 1 | All fifteen entries are valid |

## Verification
The bench builds the unit with its default parameters: eight key words and fourteen rounds. This is the only configuration with both the rotate-substitute rule and the substitute-only rule, and it reaches round-constant index 7 and the final flush to entry 14. Three keys are expanded: a counting pattern, a pseudo-random pattern and all ones. Every one of the 60 words is compared against an independent software model, and each word is labelled with the rule that produced it. The entries are read back in ascending, descending and interleaved address order.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int ADDR_W = 4;
  localparam int RCIDX_W = 4;

  typedef struct packed {
    logic              load;
    logic              gen;
    logic              wr;
    logic [ADDR_W-1:0] wrAddr;
    logic              rotSub;
    logic              subOnly;
    logic [RCIDX_W-1:0] rconIdx;
  } ksCtrl_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // Multiplicative inverse via a^254, then the affine map.
  function automatic logic [7:0] sboxByte(input logic [7:0] a);
    logic [7:0] inv;
    logic [7:0] p;
    logic [7:0] r;
    inv = 8'h01;
    p = a;
    for (int k = 0; k < 8; k++) begin
      if (((254 >> k) & 1) == 1) inv = gfMul(inv, p);
      p = gfMul(p, p);
    end
    r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return r;
  endfunction

  function automatic logic [31:0] subWord(input logic [31:0] w);
    return {sboxByte(w[31:24]), sboxByte(w[23:16]), sboxByte(w[15:8]), sboxByte(w[7:0])};
  endfunction

  function automatic logic [7:0] rconByte(input logic [RCIDX_W-1:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 1; k < (1 << RCIDX_W); k++) begin
      if (k < int'(idx)) r = xtime(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import aes_ks_pkg::*;
#(
  parameter int NK = 8,
  parameter int NR = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    keySegValid,
  input  logic    keyLoaded,
  output ksCtrl_t ctl,
  output logic    keysReady
);

  localparam int LAST  = NK + 4 * NR;
  localparam int CNT_W = $clog2(LAST + 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] offs;
  logic [CNT_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      keysReady <= 1'b0;
    end else if (keySegValid) begin
      st        <= ST_IDLE;
      keysReady <= 1'b0;
    end else if (keyLoaded) begin
      st        <= ST_RUN;
      cnt       <= CNT_W'(NK);
      keysReady <= 1'b0;
    end else if (st == ST_RUN) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(LAST)) begin
        st        <= ST_IDLE;
        keysReady <= 1'b1;
      end
    end
  end

  always_comb begin
    offs        = cnt - CNT_W'(NK);
    phase       = cnt % CNT_W'(NK);
    ctl.load    = keySegValid;
    ctl.gen     = (st == ST_RUN) && !keySegValid && !keyLoaded;
    ctl.wr      = ctl.gen && (cnt[1:0] == 2'b00);
    ctl.wrAddr  = offs[ADDR_W+1:2];
    ctl.rotSub  = (phase == '0);
    ctl.subOnly = (NK > 6) && (phase == CNT_W'(4));
    ctl.rconIdx = RCIDX_W'(cnt / CNT_W'(NK));
  end

endmodule

// File: rtl/ks_datapath.sv
module ks_datapath
  import aes_ks_pkg::*;
#(
  parameter int NK = 8,
  parameter int ENTRIES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ksCtrl_t             ctl,
  input  logic [31:0]         keySegIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [127:0]        rdData
);

  logic [31:0]  win [NK];
  logic [31:0]  newWord;
  logic [31:0]  shiftIn;
  logic [31:0]  rotated;
  logic [31:0]  mixed;
  logic [31:0]  rcWord;
  logic [127:0] mem [ENTRIES];
  logic         shiftEn;

  always_comb begin
    rotated = ctl.rotSub ? {win[NK-1][23:0], win[NK-1][31:24]} : win[NK-1];
    mixed   = (ctl.rotSub || ctl.subOnly) ? subWord(rotated) : win[NK-1];
    rcWord  = ctl.rotSub ? {rconByte(ctl.rconIdx), 24'h0} : 32'h0;
    newWord = win[0] ^ mixed ^ rcWord;
    shiftIn = ctl.load ? keySegIn : newWord;
    shiftEn = ctl.load || ctl.gen;
  end

  generate
    for (genvar g = 0; g < NK; g++) begin : g_win
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) win[g] <= '0;
        else if (shiftEn) begin
          if (g == NK - 1) win[g] <= shiftIn;
          else             win[g] <= win[(g + 1) % NK];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctl.wr) mem[ctl.wrAddr] <= {win[0], win[1], win[2], win[3]};
    rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/aes256_key_sched.sv
module aes256_key_sched
  import aes_ks_pkg::*;
#(
  parameter int NK = 8,
  parameter int NR = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] keySegIn,
  input  logic        keySegValid,
  input  logic        keyLoaded,
  input  logic [3:0]  rdAddr,
  output logic [127:0] rdData,
  output logic        keysReady
);

  localparam int ENTRIES = 1 << ADDR_W;

  ksCtrl_t ctl;

  ks_ctrl #(.NK(NK), .NR(NR)) u_ctrl (
    .clk(clk), .rstN(rstN), .keySegValid(keySegValid), .keyLoaded(keyLoaded),
    .ctl(ctl), .keysReady(keysReady)
  );

  ks_datapath #(.NK(NK), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keySegIn(keySegIn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/ks_checker.sv
module ks_checker (
  input logic clk,
  input logic rstN,
  input logic keySegValid,
  input logic keyLoaded,
  input logic keysReady,
  input logic wrEn
);

  logic [6:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= 7'd127;
    else if (keyLoaded) sinceStart <= 7'd0;
    else if (sinceStart != 7'd127) sinceStart <= sinceStart + 7'd1;
  end

  // R2: completion comes exactly 57 edges after the start edge
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keysReady) |-> (sinceStart == 7'd57));

  // R8: a segment load clears the flag on the next edge
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    keySegValid |=> !keysReady);

  // R8: a start pulse clears the flag on the next edge
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    keyLoaded |=> !keysReady);

  // R8: with no load or start, the flag holds once set
  assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keysReady && !keySegValid && !keyLoaded) |=> keysReady);

  // R6: the RAM is never written while the keys are reported ready
  assert_no_write_when_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    keysReady |-> !wrEn);

endmodule

bind aes256_key_sched ks_checker u_ks_checker (
  .clk(clk), .rstN(rstN), .keySegValid(keySegValid), .keyLoaded(keyLoaded),
  .keysReady(keysReady), .wrEn(ctl.wr)
);

// File: tb/aes256_key_sched_bench.sv
`timescale 1ns/1ps
module aes256_key_sched_bench;

  typedef struct {
    int           addr;
    logic [127:0] data;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  keySegIn = '0;
  logic         keySegValid = 1'b0;
  logic         keyLoaded = 1'b0;
  logic [3:0]   rdAddr = '0;
  logic [127:0] rdData;
  logic         keysReady;

  int checks = 0;
  int errors = 0;
  logic rdReq = 1'b0;
  logic reqD = 1'b0;
  item_t expQ[$];

  logic [7:0]  sbox [256];
  logic [31:0] keyW [8];
  logic [31:0] expW [60];

  always #5 clk = ~clk;

  aes256_key_sched u_aes256_key_sched (
    .clk(clk), .rstN(rstN), .keySegIn(keySegIn), .keySegValid(keySegValid),
    .keyLoaded(keyLoaded), .rdAddr(rdAddr), .rdData(rdData), .keysReady(keysReady)
  );

  // Reference S-box built by walking generator 3 and its inverse.
  task automatic buildSbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
      sbox[p] = x;
    end while (p != 8'h01);
    sbox[0] = 8'h63;
  endtask

  function automatic logic [31:0] refSub(input logic [31:0] w);
    return {sbox[w[31:24]], sbox[w[23:16]], sbox[w[15:8]], sbox[w[7:0]]};
  endfunction

  task automatic buildExpected();
    logic [7:0] rc [8];
    rc[0] = 8'h00; rc[1] = 8'h01; rc[2] = 8'h02; rc[3] = 8'h04;
    rc[4] = 8'h08; rc[5] = 8'h10; rc[6] = 8'h20; rc[7] = 8'h40;
    for (int i = 0; i < 8; i++) expW[i] = keyW[i];
    for (int i = 8; i < 60; i++) begin
      logic [31:0] t;
      t = expW[i-1];
      if (i % 8 == 0) t = refSub({t[23:0], t[31:24]}) ^ {rc[i/8], 24'h0};
      else if (i % 8 == 4) t = refSub(t);
      expW[i] = expW[i-8] ^ t;
    end
  endtask

  function automatic string ruleOf(input int i);
    if (i < 8) return "R1";
    if (i % 8 == 0) return "R4";
    if (i % 8 == 4) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: request one entry and queue its expected contents.
  task automatic readEntry(input int k);
    item_t it;
    @(negedge clk);
    rdAddr = 4'(k);
    rdReq = 1'b1;
    it.addr = k;
    it.data = {expW[4*k], expW[4*k+1], expW[4*k+2], expW[4*k+3]};
    expQ.push_back(it);
  endtask

  task automatic drainReads();
    @(negedge clk);
    rdReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) reqD <= rdReq;

  // Monitor: compare each returned entry word by word (R6 packing, R7 latency).
  always @(negedge clk) begin
    if (reqD) begin
      item_t it;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 data returned with no request: actual %h expected none", rdData);
      end else begin
        it = expQ.pop_front();
        for (int j = 0; j < 4; j++) begin
          int wi;
          wi = 4 * it.addr + j;
          check(ruleOf(wi), $sformatf("R6/R7 entry %0d word W[%0d]", it.addr, wi),
                128'(rdData[127-32*j -: 32]), 128'(expW[wi]));
        end
      end
    end
  end

  task automatic loadKey();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      keySegIn = keyW[i];
      keySegValid = 1'b1;
    end
    @(negedge clk);
    keySegValid = 1'b0;
    check("R8", "ready low after key load", 128'(keysReady), 128'(0));
  endtask

  task automatic runExpansion();
    int cyc;
    keyLoaded = 1'b1;
    @(negedge clk);
    keyLoaded = 1'b0;
    check("R8", "ready low right after start", 128'(keysReady), 128'(0));
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!keysReady && cyc < 200);
    check("R2", "edges from start to ready", 128'(cyc), 128'(57));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    buildSbox();
    check("R4", "model sbox[00]", 128'(sbox[8'h00]), 128'(8'h63));
    check("R5", "model sbox[53]", 128'(sbox[8'h53]), 128'(8'hed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "ready low after reset", 128'(keysReady), 128'(0));

    // Key A: counting bytes; ascending reads
    for (int i = 0; i < 8; i++) keyW[i] = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
    buildExpected();
    loadKey();
    runExpansion();
    for (int k = 0; k < 15; k++) readEntry(k);
    drainReads();
    check("R8", "ready holds while idle", 128'(keysReady), 128'(1));

    // One new segment must drop the flag
    @(negedge clk);
    keySegIn = 32'h0; keySegValid = 1'b1;
    @(negedge clk);
    keySegValid = 1'b0;
    check("R8", "ready cleared by single segment", 128'(keysReady), 128'(0));

    // Key B: pseudo-random words; descending reads
    for (int i = 0; i < 8; i++) keyW[i] = 32'h9e3779b9 * (i + 3) ^ 32'h5a5a0f0f;
    buildExpected();
    loadKey();
    runExpansion();
    for (int k = 14; k >= 0; k--) readEntry(k);
    drainReads();

    // Key C: all ones; interleaved reads
    for (int i = 0; i < 8; i++) keyW[i] = 32'hffffffff;
    buildExpected();
    loadKey();
    runExpansion();
    for (int k = 0; k < 15; k++) readEntry((k * 7) % 15);
    drainReads();
    check("R7", "all queued reads answered", 128'(expQ.size()), 128'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule